// File: doc/BRIEF.md
# Static Direction Branch Predictor

This unit sits in the fetch front end of a simple pipelined processor. For every decoded control-transfer instruction it is handed the instruction's address, a two-bit kind code and, where the instruction encodes one, a fixed target address. One cycle later it reports a taken or not-taken guess and the address to fetch next. The guess for a conditional branch comes only from comparing the encoded target with the branch's own address. A target at or below that address is a loop-closing jump and is guessed taken. A target above it is guessed not taken. Direct unconditional jumps are always guessed taken. Jumps whose target is only known at run time, such as returns or register jumps, are guessed to fall through.

Later the pipeline hands back the resolved outcome, together with the next address that was predicted for that instruction. If the real next address differs from the predicted one, the unit raises a one-cycle redirect carrying the correct address. It also keeps four saturating counters of resolved conditional branches, split by direction (forward or backward) and by outcome (taken or not taken).

Top module: `static_branch_predictor`

## Requirements
- R1: While reset is high, and on the first sample after it, predOutValid, predTaken, redirect and all four counters read zero.
- R2: A conditional branch (kind 2'b00) whose target is below its PC yields predTaken=1 and predNextPc=target one cycle after predValid.
- R3: A conditional branch whose target is above its PC yields predTaken=0 and predNextPc=PC+4 one cycle after predValid.
- R4: A conditional branch whose target equals its PC counts as backward: predTaken=1, predNextPc=target. At resolve it is counted as backward.
- R5: A direct unconditional jump (kind 2'b01) yields predTaken=1 and predNextPc=target, whatever the direction.
- R6: A dynamic-target jump (kind 2'b10 or 2'b11) yields predTaken=0 and predNextPc=PC+4. Its target input has no effect on the prediction.
- R7: When predValid is low, predOutValid is low one cycle later.
- R8: One cycle after resValid, redirect is 1 exactly when the correct next address (resTarget if resTaken, else resPc+4) differs from resPredNextPc. redirectPc then holds that correct address. Redirect is 0 after a cycle without resValid.
- R9: Each resolved conditional branch adds one, in the next cycle, to exactly one counter, chosen by direction (target <= PC is backward) and outcome. Resolves of other kinds leave all counters unchanged.
- R10: A counter at its all-ones value stays there on further increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| predValid | input | 1 | A control-transfer instruction is offered for prediction |
| predKind | input | 2 | 00 conditional, 01 direct jump, 10/11 dynamic target |
| predPc | input | 32 | Address of the instruction |
| predTarget | input | 32 | Encoded target address |
| resValid | input | 1 | A resolved outcome is offered |
| resKind | input | 2 | Kind of the resolved instruction, same code as predKind |
| resPc | input | 32 | Address of the resolved instruction |
| resTarget | input | 32 | Actual target address |
| resTaken | input | 1 | Actual outcome |
| resPredNextPc | input | 32 | Next address that was predicted for it |
| predOutValid | output | 1 | Prediction valid |
| predTaken | output | 1 | Predicted outcome |
| predNextPc | output | 32 | Predicted next fetch address |
| redirect | output | 1 | One-cycle mispredict pulse |
| redirectPc | output | 32 | Correct next fetch address on redirect |
| cntFwdTaken | output | 16 | Resolved forward conditional, taken |
| cntFwdNotTaken | output | 16 | Resolved forward conditional, not taken |
| cntBwdTaken | output | 16 | Resolved backward conditional, taken |
| cntBwdNotTaken | output | 16 | Resolved backward conditional, not taken |

## Verification
A flipped or off-by-one address compare shows up one cycle after the offending instruction, as a wrong predTaken or predNextPc. The equal-address case exposes such a fault most directly. A wrong counter-select index does not show a bad value at once. Instead, the wrong counter moves one cycle after the resolve, so the bench compares all four counters on every cycle. A broken saturation limit stays hidden until a counter reaches all ones, so one counter is driven there and pushed past it.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  typedef enum logic [1:0] {
    KIND_COND    = 2'b00,
    KIND_JUMP    = 2'b01,
    KIND_DYN_REG = 2'b10,
    KIND_DYN_RET = 2'b11
  } brKind_e;

  localparam int NUM_CNT = 4;
  // counter slot index = {backward, notTaken}
  localparam int CNT_FWD_T  = 0;
  localparam int CNT_FWD_NT = 1;
  localparam int CNT_BWD_T  = 2;
  localparam int CNT_BWD_NT = 3;

  typedef struct packed {
    logic                predLoad;
    logic                predTake;
    logic                redirect;
    logic [NUM_CNT-1:0]  cntInc;
  } strobes_t;

endpackage

// File: rtl/sbp_ctrl.sv
module sbp_ctrl
  import sbp_pkg::*;
(
  input  logic       predValid,
  input  logic [1:0] predKind,
  input  logic       predBackward,
  input  logic       resValid,
  input  logic [1:0] resKind,
  input  logic       resTaken,
  input  logic       resBackward,
  input  logic       resMismatch,
  output strobes_t   strb
);

  logic [1:0] cntSel;

  always_comb begin
    strb = '0;
    strb.predLoad = predValid;
    unique case (brKind_e'(predKind))
      KIND_COND:    strb.predTake = predBackward;
      KIND_JUMP:    strb.predTake = 1'b1;
      default:      strb.predTake = 1'b0;
    endcase
    strb.redirect = resValid && resMismatch;
    cntSel = {resBackward, !resTaken};
    if (resValid && (brKind_e'(resKind) == KIND_COND)) begin
      strb.cntInc[cntSel] = 1'b1;
    end
  end

endmodule

// File: rtl/sbp_datapath.sv
module sbp_datapath
  import sbp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             predPc,
  input  logic [ADDR_W-1:0]             predTarget,
  input  logic [ADDR_W-1:0]             resPc,
  input  logic [ADDR_W-1:0]             resTarget,
  input  logic                          resTaken,
  input  logic [ADDR_W-1:0]             resPredNextPc,
  input  strobes_t                      strb,
  output logic                          predBackward,
  output logic                          resBackward,
  output logic                          resMismatch,
  output logic                          predOutValid,
  output logic                          predTaken,
  output logic [ADDR_W-1:0]             predNextPc,
  output logic                          redirect,
  output logic [ADDR_W-1:0]             redirectPc,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);

  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(INSTR_BYTES);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;

  logic [ADDR_W-1:0] predFall;
  logic [ADDR_W-1:0] resFall;
  logic [ADDR_W-1:0] resCorrectPc;

  // equal address counts as backward
  assign predBackward = (predTarget <= predPc);
  assign resBackward  = (resTarget <= resPc);
  assign predFall     = predPc + STEP;
  assign resFall      = resPc + STEP;
  assign resCorrectPc = resTaken ? resTarget : resFall;
  assign resMismatch  = (resCorrectPc != resPredNextPc);

  always_ff @(posedge clk) begin
    if (rst) begin
      predOutValid <= 1'b0;
      predTaken    <= 1'b0;
      predNextPc   <= '0;
      redirect     <= 1'b0;
      redirectPc   <= '0;
    end else begin
      predOutValid <= strb.predLoad;
      if (strb.predLoad) begin
        predTaken  <= strb.predTake;
        predNextPc <= strb.predTake ? predTarget : predFall;
      end
      redirect <= strb.redirect;
      if (strb.redirect) begin
        redirectPc <= resCorrectPc;
      end
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[i] <= '0;
      end else if (strb.cntInc[i] && (cnt[i] != CNT_MAX)) begin
        cnt[i] <= cnt[i] + 1'b1;
      end
    end

    AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
      cnt[i] >= $past(cnt[i])); // R9
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
      (cnt[i] == CNT_MAX) |=> (cnt[i] == CNT_MAX)); // R10
  end

  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
    (predOutValid && predTaken) |-> (predNextPc == $past(predTarget))); // R2
  AST_NT_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (predOutValid && !predTaken) |-> (predNextPc == $past(predPc) + STEP)); // R3
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    predOutValid |-> $past(strb.predLoad)); // R7
  AST_REDIRECT_DIFFERS: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (redirectPc != $past(resPredNextPc))); // R8
  AST_ONE_COUNTER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.cntInc)); // R9

endmodule

// File: rtl/static_branch_predictor.sv
module static_branch_predictor
  import sbp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              predValid,
  input  logic [1:0]        predKind,
  input  logic [ADDR_W-1:0] predPc,
  input  logic [ADDR_W-1:0] predTarget,
  input  logic              resValid,
  input  logic [1:0]        resKind,
  input  logic [ADDR_W-1:0] resPc,
  input  logic [ADDR_W-1:0] resTarget,
  input  logic              resTaken,
  input  logic [ADDR_W-1:0] resPredNextPc,
  output logic              predOutValid,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predNextPc,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirectPc,
  output logic [CNT_W-1:0]  cntFwdTaken,
  output logic [CNT_W-1:0]  cntFwdNotTaken,
  output logic [CNT_W-1:0]  cntBwdTaken,
  output logic [CNT_W-1:0]  cntBwdNotTaken
);

  strobes_t                      strb;
  logic                          predBackward;
  logic                          resBackward;
  logic                          resMismatch;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

  sbp_ctrl u_ctrl (
    .predValid    (predValid),
    .predKind     (predKind),
    .predBackward (predBackward),
    .resValid     (resValid),
    .resKind      (resKind),
    .resTaken     (resTaken),
    .resBackward  (resBackward),
    .resMismatch  (resMismatch),
    .strb         (strb)
  );

  sbp_datapath #(
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W),
    .INSTR_BYTES (INSTR_BYTES)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .predPc        (predPc),
    .predTarget    (predTarget),
    .resPc         (resPc),
    .resTarget     (resTarget),
    .resTaken      (resTaken),
    .resPredNextPc (resPredNextPc),
    .strb          (strb),
    .predBackward  (predBackward),
    .resBackward   (resBackward),
    .resMismatch   (resMismatch),
    .predOutValid  (predOutValid),
    .predTaken     (predTaken),
    .predNextPc    (predNextPc),
    .redirect      (redirect),
    .redirectPc    (redirectPc),
    .cnt           (cnt)
  );

  assign cntFwdTaken    = cnt[CNT_FWD_T];
  assign cntFwdNotTaken = cnt[CNT_FWD_NT];
  assign cntBwdTaken    = cnt[CNT_BWD_T];
  assign cntBwdNotTaken = cnt[CNT_BWD_NT];

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!predOutValid && !redirect)); // R1

endmodule

// File: tb/static_branch_predictor_bench.sv
module static_branch_predictor_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CMAX = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        predValid = 1'b0;
  logic [1:0]  predKind = 2'b00;
  logic [31:0] predPc = '0;
  logic [31:0] predTarget = '0;
  logic        resValid = 1'b0;
  logic [1:0]  resKind = 2'b00;
  logic [31:0] resPc = '0;
  logic [31:0] resTarget = '0;
  logic        resTaken = 1'b0;
  logic [31:0] resPredNextPc = '0;
  logic        predOutValid, predTaken, redirect;
  logic [31:0] predNextPc, redirectPc;
  logic [15:0] cntFwdTaken, cntFwdNotTaken, cntBwdTaken, cntBwdNotTaken;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected state
  bit          eValid, eTaken, eRedir;
  logic [31:0] eNext, eRedirPc;
  logic [15:0] eCnt [4];
  string       predTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  static_branch_predictor u_static_branch_predictor (
    .clk(clk), .rst(rst),
    .predValid(predValid), .predKind(predKind), .predPc(predPc), .predTarget(predTarget),
    .resValid(resValid), .resKind(resKind), .resPc(resPc), .resTarget(resTarget),
    .resTaken(resTaken), .resPredNextPc(resPredNextPc),
    .predOutValid(predOutValid), .predTaken(predTaken), .predNextPc(predNextPc),
    .redirect(redirect), .redirectPc(redirectPc),
    .cntFwdTaken(cntFwdTaken), .cntFwdNotTaken(cntFwdNotTaken),
    .cntBwdTaken(cntBwdTaken), .cntBwdNotTaken(cntBwdNotTaken)
  );

  function automatic bit modelTake(logic [1:0] k, logic [31:0] pc, logic [31:0] tgt);
    if (k == 2'b00) return (tgt <= pc);
    if (k == 2'b01) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string tagFor(logic [1:0] k, logic [31:0] pc, logic [31:0] tgt);
    if (k == 2'b01) return "R5";
    if (k[1]) return "R6";
    if (tgt == pc) return "R4";
    if (tgt < pc) return "R2";
    return "R3";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // drive one cycle of stimulus, compute expectations, advance, check
  task automatic step(bit pv, logic [1:0] pk, logic [31:0] pp, logic [31:0] pt,
                      bit rv, logic [1:0] rk, logic [31:0] rp, logic [31:0] rt,
                      bit rtk, logic [31:0] rpn);
    logic [31:0] correct;
    int idx;
    predValid = pv; predKind = pk; predPc = pp; predTarget = pt;
    resValid = rv; resKind = rk; resPc = rp; resTarget = rt;
    resTaken = rtk; resPredNextPc = rpn;
    eValid = pv;
    if (pv) begin
      eTaken  = modelTake(pk, pp, pt);
      eNext   = eTaken ? pt : pp + 32'd4;
      predTag = tagFor(pk, pp, pt);
    end
    correct = rtk ? rt : rp + 32'd4;
    eRedir = rv && (correct != rpn);
    if (eRedir) eRedirPc = correct;
    if (rv && rk == 2'b00) begin
      idx = ((rt <= rp) ? 2 : 0) + (rtk ? 0 : 1);
      if (eCnt[idx] != CMAX) eCnt[idx] = eCnt[idx] + 16'd1;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R7 predOutValid", {31'd0, predOutValid}, {31'd0, eValid});
    if (eValid) begin
      chk({predTag, " predTaken"}, {31'd0, predTaken}, {31'd0, eTaken});
      chk({predTag, " predNextPc"}, predNextPc, eNext);
    end
    chk("R8 redirect", {31'd0, redirect}, {31'd0, eRedir});
    if (eRedir) chk("R8 redirectPc", redirectPc, eRedirPc);
    chk((eCnt[0] == CMAX) ? "R10 cntFwdTaken" : "R9 cntFwdTaken", {16'd0, cntFwdTaken}, {16'd0, eCnt[0]});
    chk("R9 cntFwdNotTaken", {16'd0, cntFwdNotTaken}, {16'd0, eCnt[1]});
    chk("R9 cntBwdTaken", {16'd0, cntBwdTaken}, {16'd0, eCnt[2]});
    chk("R9 cntBwdNotTaken", {16'd0, cntBwdNotTaken}, {16'd0, eCnt[3]});
  endtask

  function automatic logic [31:0] randTgt(logic [31:0] pc);
    int sel = $urandom % 3;
    if (sel == 0) return pc;
    if (sel == 1) return pc - 32'd4 * (32'd1 + ($urandom % 64));
    return pc + 32'd4 * (32'd1 + ($urandom % 64));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) eCnt[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 predOutValid", {31'd0, predOutValid}, 32'd0);
    chk("R1 predTaken", {31'd0, predTaken}, 32'd0);
    chk("R1 redirect", {31'd0, redirect}, 32'd0);
    chk("R1 counters", {cntFwdTaken, cntBwdNotTaken}, 32'd0);
    chk("R1 counters", {cntFwdNotTaken, cntBwdTaken}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {30'd0, predOutValid, redirect}, 32'd0);

    // directed corners
    step(1, 2'b00, 32'h1000, 32'h0F00, 1, 2'b00, 32'h2000, 32'h1FF0, 1, 32'h1FF0);   // R2, bwd taken no redirect
    step(1, 2'b00, 32'h1000, 32'h1100, 1, 2'b00, 32'h2000, 32'h2100, 1, 32'h2004);   // R3, fwd taken, redirect
    step(1, 2'b00, 32'h3000, 32'h3000, 1, 2'b00, 32'h3000, 32'h3000, 0, 32'h3000);   // R4 equal -> bwd not taken, redirect
    step(1, 2'b01, 32'h4000, 32'h5000, 1, 2'b01, 32'h4000, 32'h5000, 1, 32'h5000);   // R5 fwd jump
    step(1, 2'b10, 32'h6000, 32'h1000, 1, 2'b10, 32'h6000, 32'h1234, 1, 32'h6004);   // R6 dynamic, R9 no count
    step(1, 2'b11, 32'h7000, 32'h7000, 0, 2'b00, 32'h0, 32'h0, 0, 32'h0);            // R6 dyn ret, R8 no resolve
    step(0, 2'b00, 32'h8000, 32'h7000, 0, 2'b00, 32'h0, 32'h0, 0, 32'h0);            // R7

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] pp, rp, rt, good;
      logic [1:0]  pk, rk;
      bit          rtk;
      pp  = 32'h0010_0000 + 32'd4 * ($urandom % 32'h0010_0000);
      rp  = 32'h0010_0000 + 32'd4 * ($urandom % 32'h0010_0000);
      pk  = 2'($urandom);
      rk  = 2'($urandom);
      rt  = randTgt(rp);
      rtk = ($urandom % 2) == 1;
      if (rk == 2'b01) rtk = 1'b1;
      good = rtk ? rt : rp + 32'd4;
      step(($urandom % 4) != 0, pk, pp, randTgt(pp),
           ($urandom % 4) != 0, rk, rp, rt, rtk,
           (($urandom % 2) == 1) ? good : (rtk ? rp + 32'd4 : rt + 32'd8));
    end

    // saturation of the forward-taken counter
    for (int n = 0; n < 65540; n++) begin
      step(0, 2'b00, 32'h0, 32'h0, 1, 2'b00, 32'h9000, 32'h9100, 1, 32'h9100);
    end
    chk("R10 cntFwdTaken saturated", {16'd0, cntFwdTaken}, {16'd0, CMAX});

    finishRun();
  end

endmodule